// File: doc/BRIEF.md
# Costas Phase Tracking Loop Filter

This block performs fine carrier phase tracking on despread complex symbols once a preceding frequency loop has pulled the residual offset to within about 10 Hz. For every valid symbol it derives a hard-decision phase error from the signs of the in-phase and quadrature samples. The error is +1 when the two have the same sign and -1 when their signs differ. It is 0 when either sample is exactly zero.

The error drives a proportional-plus-integral (second-order) loop filter. The integrator gives the loop infinite DC gain, so a constant frequency offset is tracked with no steady-state phase or frequency error. The filter output is a registered control word for the NCO, which lies outside this block.

To hand over from the frequency loop without a jump, the integrator and the output are loaded with the frequency loop's final control word when the enable input rises. Both registers saturate at the signed full-scale limits and never wrap.

Top module: `costas_pll`

## Requirements
- R1: While `rst` is high at a rising clock edge, the integrator and `ctrl_word` clear to 0 from that edge on, whatever the other inputs are.
- R2: On the first clock edge where `en` is high after being low (or after reset), both the integrator and `ctrl_word` take the value of `preload_word`. It is visible after that edge. A symbol presented in that same cycle is ignored.
- R3: The phase error is +1 when `sym_i` and `sym_q` are both nonzero and have equal sign bits. It is -1 when both are nonzero and their sign bits differ. Internally it is encoded as the 2-bit signed values 01 and 11.
- R4: If `sym_i` or `sym_q` is exactly zero, the error is 0 and neither the integrator nor `ctrl_word` changes for that symbol.
- R5: For each accepted symbol with nonzero error e, the integrator becomes sat(integ + e*KI_GAIN), and then `ctrl_word` becomes sat(new integ + e*KP_GAIN). The result appears after the one clock edge that accepts the symbol.
- R6: In a cycle with `en` high and `sym_valid` low, `ctrl_word` and the integrator hold their values.
- R7: While `en` is low, symbols are ignored and `ctrl_word` holds its value.
- R8: The integrator and `ctrl_word` saturate at the signed CW_W-bit limits (+2^(CW_W-1)-1 and -2^(CW_W-1)) and never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Tracking enable; its rising edge loads the preload word |
| preload_word | input | CW_W | Final frequency-loop control word, signed |
| sym_valid | input | 1 | A despread symbol is present this cycle |
| sym_i | input | IN_W | In-phase symbol sample, signed |
| sym_q | input | IN_W | Quadrature symbol sample, signed |
| ctrl_word | output | CW_W | Registered signed NCO control word |

## Verification
The integrator is never visible directly. However, every accepted symbol writes the integrator plus or minus the proportional gain to `ctrl_word`. A corrupted integrator therefore shows up at the port on the very next accepted symbol with nonzero error, as an offset that persists on every later symbol. A wrong preload, a wrap instead of a clamp, or an update on a zero-error or idle cycle each produces a mismatch one clock after the offending cycle. The bench compares every cycle against a reference model so that such a divergence is caught at once.

// File: rtl/costas_pll_pkg.sv
package costas_pll_pkg;
  // Hard-decision phase error, two-bit signed
  typedef logic signed [1:0] perr_t;
  localparam perr_t ERR_ZERO = 2'sb00;
  localparam perr_t ERR_POS  = 2'sb01;
  localparam perr_t ERR_NEG  = 2'sb11;

  // Filter action chosen per cycle
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_LOAD = 2'd1,
    ACT_STEP = 2'd2
  } act_e;
endpackage

// File: rtl/costas_phase_det.sv
module costas_phase_det
  import costas_pll_pkg::*;
#(
  parameter int IN_W = 12
) (
  input  logic signed [IN_W-1:0] i_in,
  input  logic signed [IN_W-1:0] q_in,
  output perr_t                  err
);
  // sign(I*Q) without a multiplier: compare sign bits, zero wins
  always_comb begin
    if (i_in == '0 || q_in == '0)
      err = ERR_ZERO;
    else if (i_in[IN_W-1] == q_in[IN_W-1])
      err = ERR_POS;
    else
      err = ERR_NEG;
  end
endmodule

// File: rtl/costas_pll_ctrl.sv
module costas_pll_ctrl
  import costas_pll_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic sym_valid,
  output act_e act
);
  logic en_d;

  always_ff @(posedge clk) begin
    if (rst) en_d <= 1'b0;
    else     en_d <= en;
  end

  // Preload wins over any symbol in the enable-rise cycle
  always_comb begin
    if (en && !en_d)               act = ACT_LOAD;
    else if (en && en_d && sym_valid) act = ACT_STEP;
    else                           act = ACT_HOLD;
  end
endmodule

// File: rtl/costas_loop_filter.sv
module costas_loop_filter
  import costas_pll_pkg::*;
#(
  parameter int CW_W    = 16,
  parameter int KP_GAIN = 96,
  parameter int KI_GAIN = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  act_e                   act,
  input  logic signed [CW_W-1:0] load_val,
  input  perr_t                  err,
  output logic signed [CW_W-1:0] ctrl_q
);
  // Two guard bits cover one gain step beyond full scale
  localparam int SW = CW_W + 2;
  localparam logic signed [SW-1:0] MAXV = SW'((64'sd1 <<< (CW_W - 1)) - 64'sd1);
  localparam logic signed [SW-1:0] MINV = -MAXV - SW'(1);
  localparam logic signed [SW-1:0] KP_S = SW'(KP_GAIN);
  localparam logic signed [SW-1:0] KI_S = SW'(KI_GAIN);

  logic signed [CW_W-1:0] integ_q;
  logic signed [SW-1:0]   i_sum, c_sum;
  logic signed [CW_W-1:0] i_new, c_new;

  function automatic logic signed [CW_W-1:0] clamp(input logic signed [SW-1:0] v);
    logic signed [SW-1:0] r;
    if (v > MAXV)      r = MAXV;
    else if (v < MINV) r = MINV;
    else               r = v;
    return CW_W'(r);
  endfunction

  always_comb begin
    if (err == ERR_POS) i_sum = SW'(integ_q) + KI_S;
    else                i_sum = SW'(integ_q) - KI_S;
    i_new = clamp(i_sum);
    if (err == ERR_POS) c_sum = SW'(i_new) + KP_S;
    else                c_sum = SW'(i_new) - KP_S;
    c_new = clamp(c_sum);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      integ_q <= '0;
      ctrl_q  <= '0;
    end else if (act == ACT_LOAD) begin
      integ_q <= load_val;
      ctrl_q  <= load_val;
    end else if (act == ACT_STEP && err != ERR_ZERO) begin
      integ_q <= i_new;
      ctrl_q  <= c_new;
    end
  end
endmodule

// File: rtl/costas_pll.sv
module costas_pll
  import costas_pll_pkg::*;
#(
  parameter int IN_W    = 12,
  parameter int CW_W    = 16,
  parameter int KP_GAIN = 96,
  parameter int KI_GAIN = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic signed [CW_W-1:0] preload_word,
  input  logic                   sym_valid,
  input  logic signed [IN_W-1:0] sym_i,
  input  logic signed [IN_W-1:0] sym_q,
  output logic signed [CW_W-1:0] ctrl_word
);
  perr_t err;
  act_e  act;

  costas_phase_det #(.IN_W(IN_W)) u_det (
    .i_in (sym_i),
    .q_in (sym_q),
    .err  (err)
  );

  costas_pll_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .sym_valid (sym_valid),
    .act       (act)
  );

  costas_loop_filter #(
    .CW_W    (CW_W),
    .KP_GAIN (KP_GAIN),
    .KI_GAIN (KI_GAIN)
  ) u_filt (
    .clk      (clk),
    .rst      (rst),
    .act      (act),
    .load_val (preload_word),
    .err      (err),
    .ctrl_q   (ctrl_word)
  );
endmodule

// File: rtl/costas_pll_chk.sv
module costas_pll_chk #(
  parameter int IN_W = 12,
  parameter int CW_W = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   en,
  input logic signed [CW_W-1:0] preload_word,
  input logic                   sym_valid,
  input logic signed [IN_W-1:0] sym_i,
  input logic signed [IN_W-1:0] sym_q,
  input logic signed [CW_W-1:0] ctrl_word
);
  localparam logic signed [CW_W-1:0] CMAX = {1'b0, {(CW_W-1){1'b1}}};

  logic en_q;
  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= en;
  end

  logic tracking, nz, same_sgn;
  assign tracking = en && en_q && sym_valid;
  assign nz       = (sym_i != '0) && (sym_q != '0);
  assign same_sgn = (sym_i[IN_W-1] == sym_q[IN_W-1]);

  p_reset_zero_r1: assert property (@(posedge clk) rst |=> ctrl_word == '0);

  p_preload_r2: assert property (@(posedge clk) disable iff (rst)
    (en && !en_q) |=> ctrl_word == $past(preload_word));

  p_pos_rise_r3: assert property (@(posedge clk) disable iff (rst)
    (tracking && nz && same_sgn) |=> ctrl_word >= $past(ctrl_word));

  p_neg_fall_r3: assert property (@(posedge clk) disable iff (rst)
    (tracking && nz && !same_sgn) |=> ctrl_word <= $past(ctrl_word));

  p_zero_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (tracking && !nz) |=> $stable(ctrl_word));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (en && en_q && !sym_valid) |=> $stable(ctrl_word));

  p_off_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(ctrl_word));

  p_no_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (tracking && nz && same_sgn && ctrl_word == CMAX) |=> ctrl_word == CMAX);
endmodule

bind costas_pll costas_pll_chk #(.IN_W(IN_W), .CW_W(CW_W)) u_chk (.*);

// File: tb/tb_costas_pll.sv
module tb_costas_pll;
  localparam int IN_W = 12;
  localparam int CW_W = 16;
  localparam int KP = 96;
  localparam int KI = 5;
  localparam int CLK_PERIOD = 10;
  localparam longint MAXV = (64'sd1 <<< (CW_W - 1)) - 1;
  localparam longint MINV = -MAXV - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic signed [CW_W-1:0] preload_word = '0;
  logic sym_valid = 1'b0;
  logic signed [IN_W-1:0] sym_i = '0;
  logic signed [IN_W-1:0] sym_q = '0;
  logic signed [CW_W-1:0] ctrl_word;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference state
  longint m_int = 0;
  longint m_ctl = 0;
  bit     m_en  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  costas_pll #(.IN_W(IN_W), .CW_W(CW_W), .KP_GAIN(KP), .KI_GAIN(KI)) dut (
    .clk(clk), .rst(rst), .en(en), .preload_word(preload_word),
    .sym_valid(sym_valid), .sym_i(sym_i), .sym_q(sym_q), .ctrl_word(ctrl_word)
  );

  function automatic longint clampl(longint v);
    if (v > MAXV) return MAXV;
    if (v < MINV) return MINV;
    return v;
  endfunction

  function automatic int sgn(longint v);
    if (v > 0) return 1;
    if (v < 0) return -1;
    return 0;
  endfunction

  // Reference behaviour per requirement, applied for one clock edge
  task automatic model_edge();
    int e;
    if (rst) begin
      m_int = 0; m_ctl = 0; m_en = 0;
    end else begin
      if (en && !m_en) begin
        m_int = preload_word; m_ctl = preload_word;
      end else if (en && m_en && sym_valid) begin
        e = sgn(sym_i) * sgn(sym_q);
        if (e != 0) begin
          m_int = clampl(m_int + e * KI);
          m_ctl = clampl(m_int + e * KP);
        end
      end
      m_en = en;
    end
  endtask

  task automatic check(string tag);
    total++;
    if (longint'(ctrl_word) != m_ctl) begin
      bad++;
      $display("FAIL %s: ctrl_word actual=%0d expected=%0d", tag, ctrl_word, m_ctl);
    end
  endtask

  // drive at negedge, let one posedge pass, compare at following negedge
  task automatic cyc(bit r, bit e, longint pre, bit v, longint i, longint q, string tag);
    rst = r; en = e; preload_word = CW_W'(pre); sym_valid = v;
    sym_i = IN_W'(i); sym_q = IN_W'(q);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag);
  endtask

  task automatic check_val(longint exp, string tag);
    total++;
    if (longint'(ctrl_word) != exp) begin
      bad++;
      $display("FAIL %s: ctrl_word actual=%0d expected=%0d", tag, ctrl_word, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    // R1: reset with busy inputs
    cyc(1, 1, 777, 1, 5, 5, "R1");
    cyc(1, 1, 777, 1, 5, 5, "R1");
    check_val(0, "R1");
    cyc(0, 0, 777, 1, 5, 5, "R7");
    // R2: rise loads, symbol in same cycle ignored
    cyc(0, 1, 1000, 1, 9, 9, "R2");
    check_val(1000, "R2");
    // R3/R5: positive error
    cyc(0, 1, 0, 1, 5, 7, "R3");
    check_val(1101, "R5");
    cyc(0, 1, 0, 1, -5, -7, "R5");
    check_val(1106, "R5");
    // R3: opposite signs give -1
    cyc(0, 1, 0, 1, -3, 4, "R3");
    check_val(909, "R3");
    // R4: zero sample, no change
    cyc(0, 1, 0, 1, 0, 100, "R4");
    cyc(0, 1, 0, 1, -100, 0, "R4");
    check_val(909, "R4");
    // R6: no valid, hold
    cyc(0, 1, 0, 0, 50, 50, "R6");
    cyc(0, 1, 0, 0, -50, 50, "R6");
    // R7: enable low ignores symbols
    cyc(0, 0, 0, 1, 50, 50, "R7");
    cyc(0, 0, 0, 1, 50, 50, "R7");
    check_val(909, "R7");
    // R8: positive saturation
    cyc(0, 1, 32760, 0, 0, 0, "R2");
    for (int k = 0; k < 3; k++) cyc(0, 1, 0, 1, 1, 1, "R8");
    check_val(32767, "R8");
    cyc(0, 1, 0, 1, 1, -1, "R8");
    check_val(32666, "R8");
    // R8: negative saturation
    cyc(0, 0, 0, 0, 0, 0, "R7");
    cyc(0, 1, -32765, 0, 0, 0, "R2");
    for (int k = 0; k < 3; k++) cyc(0, 1, 0, 1, -2, 2, "R8");
    check_val(-32768, "R8");
    cyc(0, 1, 0, 1, 2, 2, "R8");
    check_val(-32667, "R8");
    // random mix
    for (int n = 0; n < 3000; n++) begin
      bit e;
      bit v;
      longint i;
      longint q;
      e = ($urandom_range(0, 19) != 0);
      v = ($urandom_range(0, 3) != 0);
      i = ($urandom_range(0, 9) == 0) ? 0 : longint'($signed(IN_W'($urandom)));
      q = ($urandom_range(0, 9) == 0) ? 0 : longint'($signed(IN_W'($urandom)));
      cyc(($urandom_range(0, 499) == 0), e, longint'($signed(CW_W'($urandom))), v, i, q, "R5");
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule